// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditionally executed instruction or a conditional branch is allowed to proceed. It takes a 4-bit condition selector and the four arithmetic status flags, and it returns a single pass bit. The flags are negative (N), zero (Z), carry (C) and overflow (V). The sixteen selector values cover several groups:

- single-flag tests;
- unsigned magnitude comparisons, built from carry and zero;
- signed magnitude comparisons, built from negative, overflow and zero;
- an unconditional "always" code, with a second selector value that also always passes.

Two outputs are provided. The pass bit is available combinationally in the same cycle as the inputs. A registered copy, qualified by a valid strobe, is available one cycle after each valid input. The registered copy lets a stream of condition/flag pairs be pipelined back to back. Flag generation, instruction decode and branch target arithmetic belong to neighbouring blocks.

Top module: `cond_eval_unit`

## Requirements
- R1: Selector 0 passes exactly when Z=1; selector 1 passes exactly when Z=0. The flag bus bit positions are: bit 3 is N, bit 2 is Z, bit 1 is C, bit 0 is V.
- R2: Selector 2 (carry set, also unsigned higher-or-same) passes when C=1; selector 3 (carry clear, also unsigned lower) passes when C=0.
- R3: Selector 4 passes when N=1, selector 5 when N=0, selector 6 when V=1, and selector 7 when V=0.
- R4: Selector 8 (unsigned higher) passes only when C=1 and Z=0; selector 9 (unsigned lower-or-same) passes when C=0 or Z=1.
- R5: Selector 10 (signed greater-or-equal) passes when N equals V; selector 11 (signed less) passes when N differs from V.
- R6: Selector 12 (signed greater) passes when Z=0 and N equals V; selector 13 (signed less-or-equal) passes when Z=1 or N differs from V.
- R7: Selectors 14 and 15 pass for every flag combination.
- R8: One cycle after a cycle with inValid=1, outValid is 1 and passReg equals the pass result of that cycle's inputs. After a cycle with inValid=0, outValid is 0 and passReg keeps its previous value.
- R9: While rst_n is low, outValid and passReg are 0.
- R10: For every even selector below 14, and for every flag combination, the selector and the next higher selector give opposite results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered result |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks condCode/statusFlags as a vector to be registered |
| condCode | input | 4 | Condition selector, 0 to 15 |
| statusFlags | input | 4 | Status flags {N, Z, C, V} |
| passNow | output | 1 | Combinational pass result for the current inputs |
| outValid | output | 1 | Registered result is valid this cycle |
| passReg | output | 1 | Registered pass result |

## Verification
Two functions meet in the same cycle. The combinational path evaluates a fresh selector/flag pair while the register presents the result of the pair from the cycle before. To provoke this, all 256 selector/flag pairs are streamed back to back. Every fifth cycle drops inValid while the inputs keep changing, and a reset is forced mid-stream. On every clock, a behavioural model predicts both passNow and the registered pair {outValid, passReg}, so a capture that takes the new inputs instead of the held ones, or that updates on an idle cycle, shows up as a mismatch.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  parameter int CODE_W = 4;
  parameter int FLAG_W = 4;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [CODE_W-1:0] {
    COND_ZERO    = 4'd0,
    COND_NONZERO = 4'd1,
    COND_CARRY   = 4'd2,
    COND_NOCARRY = 4'd3,
    COND_NEG     = 4'd4,
    COND_POSZ    = 4'd5,
    COND_OVF     = 4'd6,
    COND_NOOVF   = 4'd7,
    COND_UGT     = 4'd8,
    COND_ULE     = 4'd9,
    COND_SGE     = 4'd10,
    COND_SLT     = 4'd11,
    COND_SGT     = 4'd12,
    COND_SLE     = 4'd13,
    COND_ALWAYS  = 4'd14,
    COND_ALWAYS2 = 4'd15
  } cond_code_e;

  typedef struct packed {
    logic capture;
  } cond_strobe_t;

endpackage

// File: rtl/cond_eval_datapath.sv
module cond_eval_datapath
  import cond_eval_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] condCode,
  input  logic [FLAG_W-1:0] statusFlags,
  input  cond_strobe_t      strobe,
  output logic              passNow,
  output logic              passHeld
);

  nzcv_t flagRec;
  assign flagRec = nzcv_t'(statusFlags);

  logic [NUM_CODES-1:0] passVec;

  // Each selector gets its own direct flag formula; the selector then picks one.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    if (g == int'(COND_ZERO)) begin : g_zero
      assign passVec[g] = flagRec.z;
    end else if (g == int'(COND_NONZERO)) begin : g_nonzero
      assign passVec[g] = ~flagRec.z;
    end else if (g == int'(COND_CARRY)) begin : g_carry
      assign passVec[g] = flagRec.c;
    end else if (g == int'(COND_NOCARRY)) begin : g_nocarry
      assign passVec[g] = ~flagRec.c;
    end else if (g == int'(COND_NEG)) begin : g_neg
      assign passVec[g] = flagRec.n;
    end else if (g == int'(COND_POSZ)) begin : g_posz
      assign passVec[g] = ~flagRec.n;
    end else if (g == int'(COND_OVF)) begin : g_ovf
      assign passVec[g] = flagRec.v;
    end else if (g == int'(COND_NOOVF)) begin : g_noovf
      assign passVec[g] = ~flagRec.v;
    end else if (g == int'(COND_UGT)) begin : g_ugt
      assign passVec[g] = flagRec.c & ~flagRec.z;
    end else if (g == int'(COND_ULE)) begin : g_ule
      assign passVec[g] = ~flagRec.c | flagRec.z;
    end else if (g == int'(COND_SGE)) begin : g_sge
      assign passVec[g] = ~(flagRec.n ^ flagRec.v);
    end else if (g == int'(COND_SLT)) begin : g_slt
      assign passVec[g] = flagRec.n ^ flagRec.v;
    end else if (g == int'(COND_SGT)) begin : g_sgt
      assign passVec[g] = ~flagRec.z & ~(flagRec.n ^ flagRec.v);
    end else if (g == int'(COND_SLE)) begin : g_sle
      assign passVec[g] = flagRec.z | (flagRec.n ^ flagRec.v);
    end else begin : g_always
      assign passVec[g] = 1'b1;
    end
  end

  assign passNow = passVec[condCode];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      passHeld <= 1'b0;
    end else if (strobe.capture) begin
      passHeld <= passNow;
    end
  end

  // Pairwise complement across the independently written formulas (R10)
  for (genvar p = 0; p < 7; p++) begin : g_pair_chk
    p_pair_complement_r10: assert property (@(posedge clk) disable iff (!rst_n)
      passVec[2*p] != passVec[2*p+1]);
  end

  p_always_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    passVec[NUM_CODES-2] && passVec[NUM_CODES-1]);

  p_zero_test_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == COND_ZERO) |-> (passNow == statusFlags[2]));

  p_unsigned_gt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == COND_UGT) |-> (passNow == (statusFlags[1] && !statusFlags[2])));

  p_signed_ge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == COND_SGE) |-> (passNow == (statusFlags[3] == statusFlags[0])));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (passHeld == $past(passNow)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(passHeld));

endmodule

// File: rtl/cond_eval_control.sv
module cond_eval_control
  import cond_eval_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output cond_strobe_t strobe,
  output logic         outValid
);

  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  p_idle_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
  import cond_eval_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [CODE_W-1:0] condCode,
  input  logic [FLAG_W-1:0] statusFlags,
  output logic              passNow,
  output logic              outValid,
  output logic              passReg
);

  cond_strobe_t strobe;

  cond_eval_control u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  cond_eval_datapath u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .condCode    (condCode),
    .statusFlags (statusFlags),
    .strobe      (strobe),
    .passNow     (passNow),
    .passHeld    (passReg)
  );

endmodule

// File: tb/cond_eval_unit_bench.sv
`timescale 1ns/1ps
module cond_eval_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inValid = 1'b0;
  logic [3:0] condCode = 4'd0;
  logic [3:0] statusFlags = 4'd0;
  logic       passNow;
  logic       outValid;
  logic       passReg;

  int checks = 0;
  int failures = 0;
  bit expValid = 1'b0;
  bit expPass = 1'b0;

  always #2.5 clk = ~clk;

  cond_eval_unit u_cond_eval_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .inValid     (inValid),
    .condCode    (condCode),
    .statusFlags (statusFlags),
    .passNow     (passNow),
    .outValid    (outValid),
    .passReg     (passReg)
  );

  // Behavioural reference: flags bit3=N, bit2=Z, bit1=C, bit0=V
  function automatic bit refPass(int code, int fl);
    bit n, z, c, v;
    n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
    case (code)
      0: return z;
      1: return !z;
      2: return c;
      3: return !c;
      4: return n;
      5: return !n;
      6: return v;
      7: return !v;
      8: return c && !z;
      9: return !c || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string reqOf(int code);
    if (code < 2) return "R1";
    if (code < 4) return "R2";
    if (code < 8) return "R3";
    if (code < 10) return "R4";
    if (code < 12) return "R5";
    if (code < 14) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic checkRegistered();
    check("R8", "outValid", int'(outValid), int'(expValid));
    check("R8", "passReg", int'(passReg), int'(expPass));
  endtask

  task automatic driveVector(int idx, bit valid);
    int code, fl;
    code = idx % 16;
    fl = (idx / 16) % 16;
    checkRegistered();
    inValid = valid;
    condCode = 4'(code);
    statusFlags = 4'(fl);
    #1;
    check(reqOf(code), $sformatf("passNow code=%0d flags=%0d", code, fl),
          int'(passNow), int'(refPass(code, fl)));
    if (valid) begin
      expValid = 1'b1;
      expPass = refPass(code, fl);
    end else begin
      expValid = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", "outValid in reset", int'(outValid), 0);
    check("R9", "passReg in reset", int'(passReg), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Stream every selector/flag pair, idle every fifth cycle (R1-R8 coverage)
    for (int i = 0; i < 320; i++) begin
      driveVector(i, (i % 5) != 4);
    end

    // R9: reset in the middle of a stream
    driveVector(5, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R9", "outValid mid-stream reset", int'(outValid), 0);
    check("R9", "passReg mid-stream reset", int'(passReg), 0);
    expValid = 1'b0;
    expPass = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkRegistered();

    // R8: a held pass=1 must survive several idle cycles with changing inputs
    driveVector(14, 1'b1);
    for (int i = 0; i < 16; i++) begin
      driveVector(16 * i + 8, 1'b0);
    end
    checkRegistered();

    // R10: neighbouring selectors disagree for every flag combination
    for (int fl = 0; fl < 16; fl++) begin
      for (int code = 0; code < 14; code += 2) begin
        bit a, b;
        statusFlags = 4'(fl);
        condCode = 4'(code);
        #0.5;
        a = passNow;
        condCode = 4'(code + 1);
        #0.5;
        b = passNow;
        check("R10", $sformatf("pair code=%0d flags=%0d differ", code, fl),
              int'(a != b), 1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule